// File: doc/BRIEF.md
# JTAG In-System Programming Status and Security Guard

This block sits between a JTAG instruction decoder and the flash engine of a programmable memory device. It takes decoded 8-bit in-system-programming opcodes, one per cycle, and does four things with them. It enables the TDO driver. It optionally brings up two extension pins that report engine state directly, so that a programmer does not have to shift status out serially. It holds a sticky error flag. It gates access commands against a non-volatile security bit.

The extension pins are a ready/busy pin and an active-low error pin. Each can be driven push-pull or as open-drain. While the device is secured, the only access command that reaches the engine is a full chip erase. The read, program and verify commands are refused with a one-cycle pulse on `blocked`. The secured state ends when the engine reports that a full erase has finished.

`rst_n` is asserted asynchronously and released synchronously inside the block, two clocks after the pin rises. `chip_rst` is a separate, synchronous, single-cycle device reset pulse. Its only effect is on the error flag, as R6 describes.

Top module: `jisp_guard`

## Requirements
- R1: While reset is applied and after it is released, `tdo_oe`, `rdy_oe`, `err_oe`, `blocked` and all four `start_*` outputs are 0. `err_pin` reads 1, and `secured` equals `secure_nv`.
- R2: A valid opcode 0x01 sets `tdo_oe` to 1 in the cycle after it is presented. The enable leaves `tdo_oe` at 1 until `rst_n` is applied.
- R3: A valid opcode 0x02 sets `tdo_oe` to 1 and also enables both extension pins in the cycle after it is presented. Opcode 0x01 alone does not enable the extension pins.
- R4: `eng_fail` high at a clock edge sets the internal error flag, and `err_pin` then reads 0. A set flag is sticky: it stays set whatever `eng_fail` does afterwards.
- R5: A valid opcode 0x03 clears the error flag from the next cycle. If `eng_fail` is high in the same cycle, the flag stays set.
- R6: A `chip_rst` pulse clears the error flag only if opcode 0x0F was accepted after the previous `chip_rst`. Every `chip_rst` pulse forgets a recorded 0x0F, unless a new 0x0F arrives in the same cycle.
- R7: One cycle after the inputs are applied, the ready level is `eng_read_array & ~eng_busy & ~eng_sec_write`. In push-pull mode `rdy_pin` equals that level.
- R8: Opcode 0x04 selects open-drain mode for both extension pins and opcode 0x05 selects push-pull mode. In open-drain mode a pin reads 0, and its output enable is 1 only while its level is 0.
- R9: While `secured` is 1, opcodes 0x10 (read), 0x11 (program) and 0x12 (verify) produce a one-cycle `blocked` pulse in the next cycle and raise no `start_*` output.
- R10: Opcode 0x13 raises `start_erase` for one cycle whether or not the device is secured. After an `eng_erase_done` pulse, `secured` is 0 until the next `rst_n`.
- R11: While unsecured, opcodes 0x10, 0x11 and 0x12 raise `start_read`, `start_prog` and `start_verify` respectively, each for exactly one cycle, in the cycle after the opcode.
- R12: Until opcode 0x02 has been accepted, `rdy_oe` and `err_oe` stay 0, whatever the error flag, the engine status or the drive mode.
- R13: A valid opcode outside the set {0x01–0x05, 0x0F, 0x10–0x13} changes no output and no internal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_valid | input | 1 | `cmd_op` holds a decoded opcode this cycle |
| cmd_op | input | 8 | Decoded opcode |
| chip_rst | input | 1 | Single-cycle device reset pulse |
| secure_nv | input | 1 | Non-volatile security bit |
| eng_busy | input | 1 | Flash program or erase in progress |
| eng_fail | input | 1 | Sector erase or byte program failed |
| eng_read_array | input | 1 | Engine is in read-array mode |
| eng_sec_write | input | 1 | Secondary flash block is being written |
| eng_erase_done | input | 1 | Full chip erase finished |
| tdo_oe | output | 1 | TDO driver enable |
| rdy_pin | output | 1 | Ready/busy pin value |
| rdy_oe | output | 1 | Ready/busy pin driver enable |
| err_pin | output | 1 | Active-low error pin value |
| err_oe | output | 1 | Error pin driver enable |
| start_read | output | 1 | Start a read in the engine |
| start_prog | output | 1 | Start a program operation in the engine |
| start_verify | output | 1 | Start a verify in the engine |
| start_erase | output | 1 | Start a full chip erase in the engine |
| blocked | output | 1 | A command was refused because the device is secured |
| secured | output | 1 | Device is currently secured |

## Verification
A wrong internal state shows at the ports one cycle after the command or status event that exposes it.

- A lost or spurious enable appears as `tdo_oe`, or as `rdy_oe`/`err_oe`, taking the wrong value on the next cycle.
- A wrong drive-mode bit turns a released pin into a driven one on the next status change.
- An error flag that was not cleared, or was cleared wrongly, shows at once on `err_pin` once the extension pins are enabled. While they are disabled it stays hidden behind a zero `err_oe` until opcode 0x02 arrives.
- A wrong security state first appears on `secured` itself. Its effect on commands appears with the next access opcode, as a `start_*` pulse where `blocked` was due, or the reverse.

// File: rtl/jisp_pkg.sv
package jisp_pkg;
  localparam int OP_W = 8;

  typedef enum logic [OP_W-1:0] {
    OP_EN      = 8'h01,
    OP_EN_EXT  = 8'h02,
    OP_CLR_ERR = 8'h03,
    OP_OD      = 8'h04,
    OP_PP      = 8'h05,
    OP_DIS     = 8'h0F,
    OP_READ    = 8'h10,
    OP_PROG    = 8'h11,
    OP_VERIFY  = 8'h12,
    OP_ERASE   = 8'h13
  } op_e;

  typedef struct packed {
    logic en;
    logic en_ext;
    logic clr_err;
    logic od;
    logic pp;
    logic dis;
    logic rd;
    logic pg;
    logic vf;
    logic er;
  } cmd_hit_t;

  function automatic cmd_hit_t decode_op(input logic vld, input logic [OP_W-1:0] op);
    cmd_hit_t h;
    h         = '0;
    h.en      = vld && (op == OP_EN);
    h.en_ext  = vld && (op == OP_EN_EXT);
    h.clr_err = vld && (op == OP_CLR_ERR);
    h.od      = vld && (op == OP_OD);
    h.pp      = vld && (op == OP_PP);
    h.dis     = vld && (op == OP_DIS);
    h.rd      = vld && (op == OP_READ);
    h.pg      = vld && (op == OP_PROG);
    h.vf      = vld && (op == OP_VERIFY);
    h.er      = vld && (op == OP_ERASE);
    return h;
  endfunction
endpackage

// File: rtl/jisp_rst_sync.sv
module jisp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/jisp_mode_regs.sv
module jisp_mode_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_en,
  input  logic hit_en_ext,
  input  logic hit_od,
  input  logic hit_pp,
  input  logic hit_dis,
  input  logic chip_rst,
  input  logic erase_done,
  output logic en_q,
  output logic ext_q,
  output logic od_q,
  output logic dis_q,
  output logic wiped_q
);
  logic en_d, ext_d, od_d, dis_d, wiped_d;
  logic od_ce;

  always_comb begin
    en_d    = en_q | hit_en | hit_en_ext;
    ext_d   = ext_q | hit_en_ext;
    od_ce   = hit_od | hit_pp;
    od_d    = hit_od;
    dis_d   = hit_dis | (dis_q & ~chip_rst);
    wiped_d = wiped_q | erase_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      ext_q   <= 1'b0;
      od_q    <= 1'b0;
      dis_q   <= 1'b0;
      wiped_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      ext_q   <= ext_d;
      if (od_ce) od_q <= od_d;
      dis_q   <= dis_d;
      wiped_q <= wiped_d;
    end
  end

  // R2
  tdo_en_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(hit_en || hit_en_ext));

  // R3
  ext_en_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_q) |-> $past(hit_en_ext));
endmodule

// File: rtl/jisp_err_track.sv
module jisp_err_track (
  input  logic clk,
  input  logic rst_n,
  input  logic fail,
  input  logic clr_cmd,
  input  logic chip_rst,
  input  logic dis_seen,
  output logic err_q
);
  logic err_d;
  logic wipe;

  always_comb begin
    wipe  = clr_cmd | (chip_rst & dis_seen);
    err_d = fail | (err_q & ~wipe);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  // R4
  err_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fail) |-> err_q);

  // R6
  err_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_q) |-> $past(clr_cmd || (chip_rst && dis_seen)));
endmodule

// File: rtl/jisp_cmd_dec.sv
module jisp_cmd_dec (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_rd,
  input  logic hit_pg,
  input  logic hit_vf,
  input  logic hit_er,
  input  logic secured,
  output logic start_rd_q,
  output logic start_pg_q,
  output logic start_vf_q,
  output logic start_er_q,
  output logic blocked_q
);
  logic rd_d, pg_d, vf_d, er_d, blk_d;

  always_comb begin
    rd_d  = hit_rd & ~secured;
    pg_d  = hit_pg & ~secured;
    vf_d  = hit_vf & ~secured;
    er_d  = hit_er;
    blk_d = secured & (hit_rd | hit_pg | hit_vf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_rd_q <= 1'b0;
      start_pg_q <= 1'b0;
      start_vf_q <= 1'b0;
      start_er_q <= 1'b0;
      blocked_q  <= 1'b0;
    end else begin
      start_rd_q <= rd_d;
      start_pg_q <= pg_d;
      start_vf_q <= vf_d;
      start_er_q <= er_d;
      blocked_q  <= blk_d;
    end
  end

  // R9
  blk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_q |-> !(start_rd_q || start_pg_q || start_vf_q));

  // R11
  start_unsec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rd_q || start_pg_q || start_vf_q) |-> $past(!secured));

  // R11
  start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_rd_q, start_pg_q, start_vf_q, start_er_q}));
endmodule

// File: rtl/jisp_pin_drv.sv
module jisp_pin_drv #(
  parameter bit REG_IN = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  input  logic ext_en,
  input  logic od_mode,
  output logic pin,
  output logic oe
);
  logic lvl;

  generate
    if (REG_IN) begin : g_reg
      logic lvl_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_in;
      end
      assign lvl = lvl_q;
    end else begin : g_pass
      logic unused_clk;
      assign unused_clk = clk;
      assign lvl = lvl_in;
    end
  endgenerate

  always_comb begin
    if (od_mode) begin
      pin = 1'b0;
      oe  = ext_en & ~lvl;
    end else begin
      pin = lvl;
      oe  = ext_en;
    end
  end

  // R12
  ext_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en |-> !oe);

  // R8
  od_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (od_mode && oe) |-> (!lvl && !pin));
endmodule

// File: rtl/jisp_guard.sv
module jisp_guard
  import jisp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [OP_W-1:0] cmd_op,
  input  logic            chip_rst,
  input  logic            secure_nv,
  input  logic            eng_busy,
  input  logic            eng_fail,
  input  logic            eng_read_array,
  input  logic            eng_sec_write,
  input  logic            eng_erase_done,
  output logic            tdo_oe,
  output logic            rdy_pin,
  output logic            rdy_oe,
  output logic            err_pin,
  output logic            err_oe,
  output logic            start_read,
  output logic            start_prog,
  output logic            start_verify,
  output logic            start_erase,
  output logic            blocked,
  output logic            secured
);
  localparam int NPIN = 2;

  logic     srst_n;
  cmd_hit_t hit;
  logic     en_q, ext_q, od_q, dis_q, wiped_q, err_q;
  logic [NPIN-1:0] lvl_src, pin_v, oe_v;

  jisp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  always_comb hit = decode_op(cmd_valid, cmd_op);

  assign secured = secure_nv & ~wiped_q;

  jisp_mode_regs u_mode (
    .clk(clk), .rst_n(srst_n),
    .hit_en(hit.en), .hit_en_ext(hit.en_ext), .hit_od(hit.od), .hit_pp(hit.pp),
    .hit_dis(hit.dis), .chip_rst(chip_rst), .erase_done(eng_erase_done),
    .en_q(en_q), .ext_q(ext_q), .od_q(od_q), .dis_q(dis_q), .wiped_q(wiped_q)
  );

  jisp_err_track u_err (
    .clk(clk), .rst_n(srst_n), .fail(eng_fail), .clr_cmd(hit.clr_err),
    .chip_rst(chip_rst), .dis_seen(dis_q), .err_q(err_q)
  );

  jisp_cmd_dec u_dec (
    .clk(clk), .rst_n(srst_n),
    .hit_rd(hit.rd), .hit_pg(hit.pg), .hit_vf(hit.vf), .hit_er(hit.er),
    .secured(secured),
    .start_rd_q(start_read), .start_pg_q(start_prog), .start_vf_q(start_verify),
    .start_er_q(start_erase), .blocked_q(blocked)
  );

  // index 0: ready/busy (registered from engine status), index 1: error (from flag)
  assign lvl_src[0] = eng_read_array & ~eng_busy & ~eng_sec_write;
  assign lvl_src[1] = ~err_q;

  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
      jisp_pin_drv #(.REG_IN(i == 0)) u_pin (
        .clk(clk), .rst_n(srst_n), .lvl_in(lvl_src[i]),
        .ext_en(ext_q), .od_mode(od_q), .pin(pin_v[i]), .oe(oe_v[i])
      );
    end
  endgenerate

  assign tdo_oe  = en_q;
  assign rdy_pin = pin_v[0];
  assign rdy_oe  = oe_v[0];
  assign err_pin = pin_v[1];
  assign err_oe  = oe_v[1];

  // R10
  wipe_unsecures_chk: assert property (@(posedge srst_n ? clk : 1'b0) disable iff (!srst_n)
    $past(eng_erase_done) |-> !secured);

  // R12
  ext_needs_tdo_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (rdy_oe || err_oe) |-> tdo_oe);
endmodule

// File: tb/jisp_guard_test.sv
`timescale 1ns/1ps
module jisp_guard_test;
  logic clk = 1'b0;
  logic rst_n;
  logic v, crst, snv, busy, fail, ra, sw, edone;
  logic [7:0] op;
  logic tdo_oe, rdy_pin, rdy_oe, err_pin, err_oe;
  logic s_rd, s_pg, s_vf, s_er, blk, sec;

  int total = 0;
  int bad   = 0;

  // reference state
  bit m_en, m_ext, m_od, m_dis, m_wiped, m_err, m_rdy;
  bit m_rd, m_pg, m_vf, m_er, m_blk;

  always #2 clk = ~clk;

  jisp_guard uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(v), .cmd_op(op), .chip_rst(crst),
    .secure_nv(snv), .eng_busy(busy), .eng_fail(fail), .eng_read_array(ra),
    .eng_sec_write(sw), .eng_erase_done(edone),
    .tdo_oe(tdo_oe), .rdy_pin(rdy_pin), .rdy_oe(rdy_oe), .err_pin(err_pin),
    .err_oe(err_oe), .start_read(s_rd), .start_prog(s_pg), .start_verify(s_vf),
    .start_erase(s_er), .blocked(blk), .secured(sec)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_pin(input bit lvl, input bit od);
    return od ? 1'b0 : lvl;
  endfunction

  function automatic bit exp_oe(input bit lvl, input bit ext, input bit od);
    return od ? (ext & ~lvl) : ext;
  endfunction

  task automatic model_clear();
    {m_en, m_ext, m_od, m_dis, m_wiped, m_err, m_rdy} = '0;
    {m_rd, m_pg, m_vf, m_er, m_blk} = '0;
  endtask

  task automatic model_step();
    bit h_en, h_ext, h_clr, h_od, h_pp, h_dis, h_rd, h_pg, h_vf, h_er, s;
    h_en  = v && op == 8'h01; h_ext = v && op == 8'h02; h_clr = v && op == 8'h03;
    h_od  = v && op == 8'h04; h_pp  = v && op == 8'h05; h_dis = v && op == 8'h0F;
    h_rd  = v && op == 8'h10; h_pg  = v && op == 8'h11; h_vf  = v && op == 8'h12;
    h_er  = v && op == 8'h13;
    s = snv & ~m_wiped;
    m_rd  = h_rd & ~s; m_pg = h_pg & ~s; m_vf = h_vf & ~s; m_er = h_er;
    m_blk = s & (h_rd | h_pg | h_vf);
    m_err = fail | (m_err & ~h_clr & ~(crst & m_dis));
    m_dis = h_dis | (m_dis & ~crst);
    m_en  = m_en | h_en | h_ext;
    m_ext = m_ext | h_ext;
    if (h_od) m_od = 1'b1; else if (h_pp) m_od = 1'b0;
    m_wiped = m_wiped | edone;
    m_rdy = ra & ~busy & ~sw;
  endtask

  task automatic compare_all();
    string toe;
    toe = !m_ext ? "R12" : (m_od ? "R8" : "R7");
    chk("R2 tdo_oe", tdo_oe, m_en);
    chk("R7 rdy_pin", rdy_pin, exp_pin(m_rdy, m_od));
    chk({toe, " rdy_oe"}, rdy_oe, exp_oe(m_rdy, m_ext, m_od));
    chk("R4 err_pin", err_pin, exp_pin(~m_err, m_od));
    chk({toe, " err_oe"}, err_oe, exp_oe(~m_err, m_ext, m_od));
    chk("R11 start_read", s_rd, m_rd);
    chk("R11 start_prog", s_pg, m_pg);
    chk("R11 start_verify", s_vf, m_vf);
    chk("R10 start_erase", s_er, m_er);
    chk("R9 blocked", blk, m_blk);
    chk("R10 secured", sec, snv & ~m_wiped);
  endtask

  task automatic cyc();
    @(posedge clk); model_step();
    @(negedge clk); compare_all();
    v = 0; crst = 0; fail = 0; edone = 0;
  endtask

  task automatic send(input logic [7:0] code);
    v = 1'b1; op = code; cyc();
  endtask

  task automatic do_reset();
    {v, crst, busy, fail, ra, sw, edone} = '0; op = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    model_clear();
    chk("R1 tdo_oe in reset", tdo_oe, 1'b0);
    chk("R1 blocked in reset", blk, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare_all();
    chk("R1 err_pin after reset", err_pin, 1'b1);
    chk("R1 rdy_oe after reset", rdy_oe, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1729));
    snv = 1'b1;
    do_reset();

    // R13: unknown opcodes
    send(8'h07); send(8'hFF); send(8'h14);
    chk("R13 tdo_oe after unknown", tdo_oe, 1'b0);
    chk("R13 no start after unknown", s_rd | s_pg | s_vf | s_er | blk, 1'b0);

    // R9: secured read refused
    send(8'h10);
    chk("R9 blocked pulse", blk, 1'b1);
    chk("R9 no start_read", s_rd, 1'b0);
    cyc();
    chk("R9 pulse one cycle", blk, 1'b0);

    // R2 / R12
    send(8'h01);
    chk("R2 tdo_oe set", tdo_oe, 1'b1);
    fail = 1'b1; cyc();
    chk("R12 err_oe off before 0x02", err_oe, 1'b0);
    chk("R12 rdy_oe off before 0x02", rdy_oe, 1'b0);

    // R3 / R4
    send(8'h02);
    chk("R3 rdy_oe on", rdy_oe, 1'b1);
    chk("R4 err_pin low sticky", err_pin, 1'b0);

    // R6
    crst = 1'b1; cyc();
    chk("R6 chip_rst without disable keeps error", err_pin, 1'b0);
    send(8'h0F);
    crst = 1'b1; cyc();
    chk("R6 chip_rst after disable clears error", err_pin, 1'b1);

    // R5
    fail = 1'b1; cyc();
    chk("R4 error set again", err_pin, 1'b0);
    send(8'h03);
    chk("R5 clear command", err_pin, 1'b1);
    fail = 1'b1; v = 1'b1; op = 8'h03; cyc();
    chk("R5 fail beats clear", err_pin, 1'b0);

    // R8
    send(8'h04);
    ra = 1'b1; cyc();
    chk("R8 od released when high", rdy_oe, 1'b0);
    chk("R8 od error driven low", err_oe, 1'b1);
    send(8'h05);
    chk("R8 push-pull rdy_pin", rdy_pin, 1'b1);

    // R10 / R11
    send(8'h13);
    chk("R10 secured erase accepted", s_er, 1'b1);
    edone = 1'b1; cyc();
    chk("R10 unsecured after erase", sec, 1'b0);
    send(8'h11);
    chk("R11 start_prog", s_pg, 1'b1);

    // random phases
    for (int ph = 0; ph < 6; ph++) begin
      snv = ph[0];
      do_reset();
      for (int n = 0; n < 500; n++) begin
        int k;
        k = $urandom_range(0, 11);
        v = ($urandom_range(0, 1) == 1);
        case (k)
          0: op = 8'h01;  1: op = 8'h02;  2: op = 8'h03;  3: op = 8'h04;
          4: op = 8'h05;  5: op = 8'h0F;  6: op = 8'h10;  7: op = 8'h11;
          8: op = 8'h12;  9: op = 8'h13;  default: op = 8'($urandom);
        endcase
        fail  = ($urandom_range(0, 15) == 0);
        crst  = ($urandom_range(0, 19) == 0);
        edone = ($urandom_range(0, 99) == 0);
        busy  = $urandom_range(0, 1);
        ra    = $urandom_range(0, 1);
        sw    = ($urandom_range(0, 3) == 0);
        cyc();
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule